// File: doc/BRIEF.md
# Synthesizer Divider Configuration Slave with Two-Wire Serial Access

This block holds the divider settings of a frequency synthesizer and lets a host change them over a two-wire serial bus in the usual I2C style, or lets a set of board pins set them directly. The settings are a 10-bit feedback divider, a 3-bit post-divider code, a one-bit secondary post-divider select and a one-bit pre-divider select. The line signals are sampled in the system clock domain, which must run much faster than the bus clock. The data line is driven only as an open-drain pull-down.

The divider latch drives the synthesizer. Two staging registers sit between the bus and that latch. A host writes the staging registers and then sends a command. The command copies the staging registers into the latch, copies the latch back into them, or steps the feedback divider up or down by one. A read returns both staging registers and a fixed identity byte in one burst.

When the mode input is low, the pins own the configuration. Bus writes are then dropped and both the latch and the staging registers track the pins. The master reset input also acts as the clock-domain reset. While it is low, everything holds its default setting. When it is released, the latch takes the pin setting.

Top module: `synth_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits are 1,0,1,1,0 followed by `adr[1]` and `adr[0]`. Bit 0 of that byte selects write (0) or read (1). After any other address the slave leaves the data line released and ignores every following byte until the next START.
- R2: A write transfer carries any number of register-address/data byte pairs, and the slave acknowledges every byte. Address 0x00 stores M[7:0]. Address 0x01 stores, from bit 7 down to bit 1, M9, M8, NA2, NA1, NA0, NB and P. Neither write changes the divider outputs.
- R3: A read transfer sends three bytes with no pointer: staging byte 0x00, then staging byte 0x01, then 0x54. The cycle continues until the host answers a byte with NACK. Bit 0 of the second byte is the `lock_i` level at the moment that byte is loaded.
- R4: Writing 0x04 to address 0xF0 (LOAD) copies the staging registers into the divider latch. A command byte whose low nibble is not exactly 0001, 0010, 0100 or 1000 does nothing. The upper nibble is never examined.
- R5: Writing 0x08 to address 0xF0 (GET) copies the divider latch into the staging registers.
- R6: Writing 0x01 (INC) or 0x02 (DEC) to address 0xF0 adds or subtracts one from the latched M, wrapping modulo 1024 with no range check. The staging registers are left unchanged.
- R7: While `ser_mode` is low, every bus write is dropped. One clock later, the divider latch and the staging registers show the parallel pins, and reads still return the staging registers.
- R8: When `ser_mode` rises, the latch and the staging registers keep their values, and later pin changes have no effect.
- R9: While `mr_n` is low, the outputs are M=500, NA=010, NB=0 and P=1, and the staging bytes are 0xF4 and 0101001x. One clock after `mr_n` rises, the latch holds the pin setting whatever `ser_mode` is. In serial mode the staging registers keep their defaults.
- R10: A STOP in the middle of a data byte abandons that byte, and no register changes.
- R11: The slave changes its data-line drive only while the synchronized bus clock is low.
- R12: The value written to bit 0 of address 0x01 is discarded, because that bit always reads as `lock_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| mr_n | input | 1 | Master reset, active low, asynchronous |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| adr | input | 2 | Variable low bits of the slave address |
| ser_mode | input | 1 | 1 = bus controls the settings, 0 = pins control them |
| lock_i | input | 1 | Synthesizer lock status |
| pin_m | input | 10 | Parallel feedback divider value |
| pin_na | input | 3 | Parallel post-divider code |
| pin_nb | input | 1 | Parallel secondary post-divider select |
| pin_p | input | 1 | Parallel pre-divider select |
| div_m | output | 10 | Latched feedback divider |
| div_na | output | 3 | Latched post-divider code |
| div_nb | output | 1 | Latched secondary post-divider select |
| div_p | output | 1 | Latched pre-divider select |

## Verification
Bus events pass through two synchronizer flops and a three-sample majority filter before the protocol engine sees them. The data-line drive therefore moves about five clocks after the bus clock edge that calls for it. The bench holds every bus-clock phase for eight clocks, so it samples acknowledges and read bits well after the drive has settled. A command takes effect two clocks after the falling bus-clock edge that completes its data byte, and pin changes in parallel mode reach the outputs one clock later. The bench reads the divider outputs several clocks after the STOP, or two clocks after a pin change, so every result is already due when it is sampled.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;

   // Divider setting as held in the latch and in the staging pair
   typedef struct packed {
      logic [9:0] m;
      logic [2:0] na;
      logic       nb;
      logic       p;
   } div_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } bus_state_t;

   localparam logic [3:0] OP_INC  = 4'b0001;
   localparam logic [3:0] OP_DEC  = 4'b0010;
   localparam logic [3:0] OP_LOAD = 4'b0100;
   localparam logic [3:0] OP_GET  = 4'b1000;

endpackage

// File: rtl/sc_line_sync.sv
`timescale 1ns/1ps
module sc_line_sync #(
   parameter int STAGES = 2,
   parameter bit FILTER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_q;
   logic [STAGES-1:0] sda_q;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
      end
   end

   generate
      if (FILTER) begin : g_filt
         logic [2:0] scl_h;
         logic [2:0] sda_h;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_h <= '1;
               sda_h <= '1;
            end else begin
               scl_h <= {scl_h[1:0], scl_q[STAGES-1]};
               sda_h <= {sda_h[1:0], sda_q[STAGES-1]};
            end
         end
         assign scl_s = (scl_h[0] & scl_h[1]) | (scl_h[0] & scl_h[2]) | (scl_h[1] & scl_h[2]);
         assign sda_s = (sda_h[0] & sda_h[1]) | (sda_h[0] & sda_h[2]) | (sda_h[1] & sda_h[2]);
      end else begin : g_direct
         assign scl_s = scl_q[STAGES-1];
         assign sda_s = sda_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/sc_bus_engine.sv
`timescale 1ns/1ps
module sc_bus_engine
   import synth_cfg_pkg::*;
#(
   parameter logic [4:0] DEV_HI = 5'b10110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [1:0] adr,
   input  logic [7:0] rd_b0,
   input  logic [7:0] rd_b1,
   input  logic [7:0] rd_b2,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data
);

   localparam int CNT_W = 4;
   localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

   bus_state_t       st;
   logic [7:0]       sh;
   logic [7:0]       tx;
   logic [7:0]       ptr;
   logic [CNT_W-1:0] cnt;
   logic             first;
   logic             pair_hi;
   logic             rw;
   logic             nack;
   logic [1:0]       idx;
   logic [1:0]       idx_nxt;

   function automatic logic [7:0] pick(input logic [1:0] i);
      case (i)
         2'd0:    pick = rd_b0;
         2'd1:    pick = rd_b1;
         default: pick = rd_b2;
      endcase
   endfunction

   assign idx_nxt = (idx == 2'd2) ? 2'd0 : idx + 2'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         sh      <= '0;
         tx      <= '0;
         ptr     <= '0;
         cnt     <= '0;
         first   <= 1'b0;
         pair_hi <= 1'b0;
         rw      <= 1'b0;
         nack    <= 1'b0;
         idx     <= '0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            st      <= ST_RX;
            cnt     <= '0;
            first   <= 1'b1;
            pair_hi <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise && cnt < BYTE_BITS) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end
                  if (scl_fall && cnt == BYTE_BITS) begin
                     cnt <= '0;
                     if (first) begin
                        if (sh[7:1] == {DEV_HI, adr}) begin
                           sda_oe <= 1'b1;
                           rw     <= sh[0];
                           st     <= ST_RX_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        sda_oe  <= 1'b1;
                        st      <= ST_RX_ACK;
                        pair_hi <= ~pair_hi;
                        if (!pair_hi) begin
                           ptr <= sh;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= sh;
                        end
                     end
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     first <= 1'b0;
                     if (first && rw) begin
                        st     <= ST_TX;
                        idx    <= 2'd0;
                        tx     <= pick(2'd0);
                        sda_oe <= ~pick(2'd0)[7];
                        cnt    <= '0;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == BYTE_BITS - 1'b1) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        st     <= ST_TX_ACK;
                     end else begin
                        cnt    <= cnt + 1'b1;
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end
                  if (scl_fall) begin
                     if (nack) begin
                        st <= ST_IDLE;
                     end else begin
                        idx    <= idx_nxt;
                        tx     <= pick(idx_nxt);
                        sda_oe <= ~pick(idx_nxt)[7];
                        st     <= ST_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/sc_cfg_store.sv
`timescale 1ns/1ps
module sc_cfg_store
   import synth_cfg_pkg::*;
#(
   parameter div_cfg_t   DEF_CFG  = '{m: 10'd500, na: 3'b010, nb: 1'b0, p: 1'b1},
   parameter logic [7:0] ADDR_LO  = 8'h00,
   parameter logic [7:0] ADDR_HI  = 8'h01,
   parameter logic [7:0] ADDR_CMD = 8'hF0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ser_mode,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   input  div_cfg_t   pins,
   output div_cfg_t   latch,
   output div_cfg_t   stage
);

   logic boot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch <= DEF_CFG;
         stage <= DEF_CFG;
         boot  <= 1'b1;
      end else begin
         boot <= 1'b0;
         if (boot || !ser_mode) begin
            latch <= pins;
         end
         if (!ser_mode) begin
            stage <= pins;
         end else if (!boot && wr_en) begin
            if (wr_addr == ADDR_LO) begin
               stage.m[7:0] <= wr_data;
            end else if (wr_addr == ADDR_HI) begin
               stage.m[9:8] <= wr_data[7:6];
               stage.na     <= wr_data[5:3];
               stage.nb     <= wr_data[2];
               stage.p      <= wr_data[1];
            end else if (wr_addr == ADDR_CMD) begin
               case (wr_data[3:0])
                  OP_INC:  latch.m <= latch.m + 10'd1;
                  OP_DEC:  latch.m <= latch.m - 10'd1;
                  OP_LOAD: latch   <= stage;
                  OP_GET:  stage   <= latch;
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/synth_cfg_slave.sv
`timescale 1ns/1ps
module synth_cfg_slave
   import synth_cfg_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter bit         LINE_FILTER = 1'b1,
   parameter logic [4:0] DEV_HI      = 5'b10110,
   parameter logic [7:0] ID_BYTE     = 8'h54,
   parameter int         DEF_M       = 500,
   parameter int         DEF_NA      = 2,
   parameter int         DEF_NB      = 0,
   parameter int         DEF_P       = 1
) (
   input  logic       clk,
   input  logic       mr_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [1:0] adr,
   input  logic       ser_mode,
   input  logic       lock_i,
   input  logic [9:0] pin_m,
   input  logic [2:0] pin_na,
   input  logic       pin_nb,
   input  logic       pin_p,
   output logic [9:0] div_m,
   output logic [2:0] div_na,
   output logic       div_nb,
   output logic       div_p
);

   localparam div_cfg_t DEF_CFG = '{m: 10'(DEF_M), na: 3'(DEF_NA), nb: 1'(DEF_NB), p: 1'(DEF_P)};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DEF_M < 0 || DEF_M > 1023) begin : g_bad_m
      $error("DEF_M must fit in 10 bits");
   end
   if (DEF_NA < 0 || DEF_NA > 7) begin : g_bad_na
      $error("DEF_NA must fit in 3 bits");
   end
   if (DEF_NB < 0 || DEF_NB > 1 || DEF_P < 0 || DEF_P > 1) begin : g_bad_bit
      $error("DEF_NB and DEF_P are single bits");
   end

   logic       scl_s;
   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_det;
   logic       stop_det;
   logic       wr_en;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;
   div_cfg_t   pins;
   div_cfg_t   latch;
   div_cfg_t   stage;
   logic [7:0] rd_b0;
   logic [7:0] rd_b1;

   sc_line_sync #(
      .STAGES (SYNC_STAGES),
      .FILTER (LINE_FILTER)
   ) u_sync (
      .clk       (clk),
      .rst_n     (mr_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   assign rd_b0 = stage.m[7:0];
   assign rd_b1 = {stage.m[9:8], stage.na, stage.nb, stage.p, lock_i};

   sc_bus_engine #(
      .DEV_HI (DEV_HI)
   ) u_eng (
      .clk       (clk),
      .rst_n     (mr_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .adr       (adr),
      .rd_b0     (rd_b0),
      .rd_b1     (rd_b1),
      .rd_b2     (ID_BYTE),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data)
   );

   assign pins = '{m: pin_m, na: pin_na, nb: pin_nb, p: pin_p};

   sc_cfg_store #(
      .DEF_CFG (DEF_CFG)
   ) u_store (
      .clk      (clk),
      .rst_n    (mr_n),
      .ser_mode (ser_mode),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pins     (pins),
      .latch    (latch),
      .stage    (stage)
   );

   assign div_m  = latch.m;
   assign div_na = latch.na;
   assign div_nb = latch.nb;
   assign div_p  = latch.p;

endmodule

// File: rtl/sc_checker.sv
`timescale 1ns/1ps
module sc_checker #(
   parameter logic [7:0] CMD_ADDR = 8'hF0
) (
   input logic       clk,
   input logic       mr_n,
   input logic       ser_mode,
   input logic [9:0] pin_m,
   input logic [9:0] div_m,
   input logic [2:0] div_na,
   input logic       div_nb,
   input logic       div_p,
   input logic       wr_en,
   input logic [7:0] wr_addr,
   input logic [7:0] wr_data,
   input logic       sda_oe,
   input logic       scl_s
);

   // R7
   par_follow_chk: assert property (@(posedge clk) disable iff (!mr_n)
      ($past(mr_n) && !$past(ser_mode)) |-> (div_m == $past(pin_m)));

   // R6
   inc_step_chk: assert property (@(posedge clk) disable iff (!mr_n)
      ($past(mr_n) && $past(ser_mode) && $past(wr_en) && $past(wr_addr) == CMD_ADDR
       && $past(wr_data[3:0]) == 4'b0001) |-> (div_m == $past(div_m) + 10'd1));

   // R6
   dec_step_chk: assert property (@(posedge clk) disable iff (!mr_n)
      ($past(mr_n) && $past(ser_mode) && $past(wr_en) && $past(wr_addr) == CMD_ADDR
       && $past(wr_data[3:0]) == 4'b0010) |-> (div_m == $past(div_m) - 10'd1));

   // R8
   serial_hold_chk: assert property (@(posedge clk) disable iff (!mr_n)
      ($past(mr_n, 2) && $past(mr_n) && $past(ser_mode) && !$past(wr_en))
      |-> ($stable(div_m) && $stable(div_na) && $stable(div_nb) && $stable(div_p)));

   // R11
   sda_low_phase_chk: assert property (@(posedge clk) disable iff (!mr_n)
      ($past(mr_n) && !$stable(sda_oe)) |-> !$past(scl_s));

endmodule

bind synth_cfg_slave sc_checker u_chk (
   .clk      (clk),
   .mr_n     (mr_n),
   .ser_mode (ser_mode),
   .pin_m    (pin_m),
   .div_m    (div_m),
   .div_na   (div_na),
   .div_nb   (div_nb),
   .div_p    (div_p),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .sda_oe   (sda_oe),
   .scl_s    (scl_s)
);

// File: tb/synth_cfg_slave_test.sv
`timescale 1ns/1ps
module synth_cfg_slave_test;

   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       mr_n = 1'b0;
   logic       tb_scl = 1'b1;
   logic       tb_low = 1'b0;
   logic [1:0] tb_adr = 2'b10;
   logic       ser_mode = 1'b1;
   logic       lock_i = 1'b1;
   logic [9:0] pin_m = 10'd321;
   logic [2:0] pin_na = 3'b100;
   logic       pin_nb = 1'b1;
   logic       pin_p = 1'b0;
   logic       sda_oe;
   logic       sda_line;
   logic [9:0] div_m;
   logic [2:0] div_na;
   logic       div_nb;
   logic       div_p;

   int n_chk = 0;
   int n_err = 0;

   // expected latch and staging contents
   logic [9:0] l_m;  logic [2:0] l_na;  logic l_nb;  logic l_p;
   logic [9:0] s_m;  logic [2:0] s_na;  logic s_nb;  logic s_p;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = ~(sda_oe | tb_low);

   synth_cfg_slave uut (
      .clk      (clk),
      .mr_n     (mr_n),
      .scl_i    (tb_scl),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .adr      (tb_adr),
      .ser_mode (ser_mode),
      .lock_i   (lock_i),
      .pin_m    (pin_m),
      .pin_na   (pin_na),
      .pin_nb   (pin_nb),
      .pin_p    (pin_p),
      .div_m    (div_m),
      .div_na   (div_na),
      .div_nb   (div_nb),
      .div_p    (div_p)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_b1(input logic lk);
      return {s_m[9:8], s_na, s_nb, s_p, lk};
   endfunction

   task automatic chk_div(input string tag);
      chk(tag, {div_m, div_na, div_nb, div_p}, {l_m, l_na, l_nb, l_p});
   endtask

   task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
      if (!ser_mode) return;
      if (a == 8'h00) s_m[7:0] = d;
      else if (a == 8'h01) begin
         s_m[9:8] = d[7:6]; s_na = d[5:3]; s_nb = d[2]; s_p = d[1];
      end else if (a == 8'hF0) begin
         case (d[3:0])
            4'b0001: l_m = l_m + 10'd1;
            4'b0010: l_m = l_m - 10'd1;
            4'b0100: begin l_m = s_m; l_na = s_na; l_nb = s_nb; l_p = s_p; end
            4'b1000: begin s_m = l_m; s_na = l_na; s_nb = l_nb; s_p = l_p; end
            default: ;
         endcase
      end
   endtask

   task automatic mdl_pins();
      l_m = pin_m; l_na = pin_na; l_nb = pin_nb; l_p = pin_p;
      s_m = pin_m; s_na = pin_na; s_nb = pin_nb; s_p = pin_p;
   endtask

   task automatic bus_start();
      tb_low = 1'b0; tb_scl = 1'b1; wait_clk(2*Q);
      tb_low = 1'b1; wait_clk(2*Q);
      tb_scl = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      tb_low = 1'b1; wait_clk(Q);
      tb_scl = 1'b1; wait_clk(2*Q);
      tb_low = 1'b0; wait_clk(2*Q);
   endtask

   task automatic wbit(input logic b);
      tb_low = ~b; wait_clk(Q);
      tb_scl = 1'b1; wait_clk(2*Q);
      tb_scl = 1'b0; wait_clk(Q);
   endtask

   task automatic wbyte(input logic [7:0] v, output logic acked);
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      tb_low = 1'b0; wait_clk(Q);
      tb_scl = 1'b1; wait_clk(Q);
      acked = ~sda_line;
      wait_clk(Q);
      tb_scl = 1'b0; wait_clk(Q);
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] v);
      tb_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         wait_clk(Q);
         tb_scl = 1'b1; wait_clk(Q);
         v[i] = sda_line;
         wait_clk(Q);
         tb_scl = 1'b0;
      end
      wait_clk(Q);
      tb_low = give_ack; wait_clk(Q);
      tb_scl = 1'b1; wait_clk(2*Q);
      tb_scl = 1'b0; wait_clk(Q);
      tb_low = 1'b0;
   endtask

   task automatic wr_txn(input int n, input logic [7:0] a0, input logic [7:0] d0,
                         input logic [7:0] a1, input logic [7:0] d1,
                         input logic [7:0] a2, input logic [7:0] d2);
      logic       ak;
      logic [7:0] aa [3];
      logic [7:0] dd [3];
      aa[0] = a0; aa[1] = a1; aa[2] = a2;
      dd[0] = d0; dd[1] = d1; dd[2] = d2;
      bus_start();
      wbyte({5'b10110, tb_adr, 1'b0}, ak);
      chk("R1 write address ack", ak, 1'b1);
      for (int k = 0; k < n; k++) begin
         wbyte(aa[k], ak);
         chk("R2 register address ack", ak, 1'b1);
         wbyte(dd[k], ak);
         chk("R2 data ack", ak, 1'b1);
         mdl_write(aa[k], dd[k]);
      end
      bus_stop();
      wait_clk(4);
   endtask

   task automatic rd_check(input string tag);
      logic       ak;
      logic [7:0] b0, b1, b2;
      bus_start();
      wbyte({5'b10110, tb_adr, 1'b1}, ak);
      chk("R1 read address ack", ak, 1'b1);
      rbyte(1'b1, b0);
      rbyte(1'b1, b1);
      rbyte(1'b0, b2);
      bus_stop();
      chk({tag, " R3 byte0"}, b0, s_m[7:0]);
      chk({tag, " R3 byte1"}, b1, exp_b1(lock_i));
      chk("R3 id byte", b2, 8'h54);
      wait_clk(4);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic ak;
      void'($urandom(32'd4242));
      wait_clk(5);
      // R9 defaults during reset
      chk("R9 reset outputs", {div_m, div_na, div_nb, div_p}, {10'd500, 3'b010, 1'b0, 1'b1});
      chk("R11 no drive in reset", sda_oe, 1'b0);
      mr_n = 1'b1;
      wait_clk(3);
      l_m = pin_m; l_na = pin_na; l_nb = pin_nb; l_p = pin_p;
      s_m = 10'd500; s_na = 3'b010; s_nb = 1'b0; s_p = 1'b1;
      chk_div("R9 latch from pins at release");
      rd_check("R9 default staging");
      chk("R9 default byte0 value", s_m[7:0], 8'hF4);

      // R1 foreign address
      bus_start();
      wbyte({5'b10110, 2'b01, 1'b0}, ak);
      chk("R1 foreign address nack", ak, 1'b0);
      wbyte(8'h00, ak);
      chk("R1 ignored after foreign", ak, 1'b0);
      wbyte(8'h12, ak);
      bus_stop();
      wait_clk(4);
      rd_check("R1 foreign write ignored");

      // R2 and R12 staging writes, latch untouched
      lock_i = 1'b0;
      wr_txn(2, 8'h00, 8'h34, 8'h01, 8'hA9, 8'h00, 8'h00);
      chk_div("R2 latch unchanged by staging write");
      rd_check("R12 lock bit from input");
      lock_i = 1'b1;
      rd_check("R12 lock bit live");

      // R4 load
      wr_txn(1, 8'hF0, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00);
      chk_div("R4 load");
      chk("R4 loaded M", div_m, 10'h234);

      // R6 wrap at top and bottom
      wr_txn(3, 8'h00, 8'hFF, 8'h01, 8'hC0, 8'hF0, 8'hF4);
      wr_txn(1, 8'hF0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
      chk("R6 inc wraps to zero", div_m, 10'd0);
      rd_check("R6 staging untouched by inc");
      wr_txn(1, 8'hF0, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00);
      chk("R6 dec wraps to top", div_m, 10'd1023);
      wr_txn(1, 8'hF0, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00);
      chk_div("R4 unknown command ignored");

      // R5 get
      wr_txn(2, 8'hF0, 8'h01, 8'h00, 8'h11, 8'h00, 8'h00);
      wr_txn(1, 8'hF0, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00);
      rd_check("R5 get");
      chk("R5 get byte0 value", s_m[7:0], 8'h00);

      // R10 stop inside a data byte
      bus_start();
      wbyte({5'b10110, tb_adr, 1'b0}, ak);
      wbyte(8'h00, ak);
      wbit(1'b1); wbit(1'b0); wbit(1'b1);
      bus_stop();
      wait_clk(4);
      rd_check("R10 partial byte dropped");

      // R7 parallel mode
      ser_mode = 1'b0;
      wait_clk(2);
      mdl_pins();
      chk_div("R7 follow pins");
      pin_m = 10'd700; pin_na = 3'b001; pin_nb = 1'b0; pin_p = 1'b1;
      wait_clk(2);
      mdl_pins();
      chk_div("R7 follow pin change");
      wr_txn(3, 8'h00, 8'h55, 8'h01, 8'h00, 8'hF0, 8'h04);
      chk_div("R7 write ignored latch");
      rd_check("R7 staging mirrors pins");

      // R8 rising mode keeps values
      ser_mode = 1'b1;
      wait_clk(2);
      pin_m = 10'd137; pin_na = 3'b110; pin_nb = 1'b1; pin_p = 1'b0;
      wait_clk(3);
      chk_div("R8 values kept after rise");
      rd_check("R8 staging kept after rise");

      // random mixed transfers
      for (int it = 0; it < 20; it++) begin
         logic [7:0] r0, r1, cmd;
         logic [1:0] sel;
         r0 = 8'($urandom);
         r1 = 8'($urandom);
         sel = 2'($urandom);
         cmd = {4'($urandom), 4'b0001 << sel};
         if (it % 5 == 4) cmd[3:0] = 4'b0110;
         lock_i = 1'($urandom);
         wr_txn(3, 8'h00, r0, 8'h01, r1, 8'hF0, cmd);
         chk_div("R2 R4 R5 R6 random latch");
         rd_check("R3 random readback");
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule